// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Collector

The block gathers 64 interrupt request lines into one processor interrupt output. Software gives every source a priority level from 0 to 3, an enable and a software trigger. The block then picks one winning source and shows a vector address for it. That address is a programmable table base plus four times the source number.

Service is tracked per priority level. A source whose level is above every level now in service interrupts the current handler. Software marks the winner as being serviced in one of two ways, chosen by a control bit: a write to the vector register, or a read of it. At the end of the handler, software writes a per-level acknowledge mask. Nesting can be turned off, so that any level in service holds off all new interrupts.

The register bus is a simple word bus with address, write strobe, read strobe, write data and combinational read data. Every register sits on a 16-byte stride. An access whose address bits [3:0] are not zero is ignored.

Top module: `irq_collector`

## Requirements
- R1: After reset, `irq_o` is 0, the control register (0x020) reads 0, and the vector register (0x000) reads 0.
- R2: Among sources that are enabled and pending (hardware line high, or software trigger set), the winner is the one at the highest level (3 highest). Between equal levels, the lowest source number wins.
- R3: `irq_o` is 1 only when all three of these hold:
  - control bit 0 (global enable) is set;
  - a winner exists;
  - the winner's level is strictly above every level in service.
- R4: The vector register (0x000) reads as the base plus 4 × the current source number. The status register (0x030) bits [5:0] give the current source number. The base is the value in register 0x160 with its bits [1:0] forced to 0. The current source follows the live winner. After a service entry it holds the entered source, until the next write to the acknowledge register.
- R5: Control bit 1 selects how a source enters service. When it is 0, entry happens on a bus write to 0x000. When it is 1, entry happens on a read-strobed access to 0x000. The other kind of access, and any access while `irq_o` is 0, causes no entry. Entry marks the winner's level as in service.
- R6: Writing 1 in bit l (l = 0..3) of the acknowledge register (0x010) ends service of level l.
- R7: When control bit 2 (nesting off) is set, any level in service blocks `irq_o`.
- R8: Source n is configured by the byte at bit offset 8×(n mod 4) of the word at 0x060 + (n div 4)×0x10. In that byte:
  - bits [1:0] are the level;
  - bit 2 is the enable;
  - bit 3 is the software trigger.
  The word reads back with bits [7:4] of each byte at 0.
- R9: Register 0x040 reads hardware request lines 0–31, and register 0x050 reads lines 32–63. Neither is masked.
- R10: A write of 1 to bit (n mod 32) of register 0x1D0 + (n div 32)×0x10 clears the software trigger of source n. Bits written as 0 leave the triggers unchanged.
- R11: Register 0x1F0 is a 32-bit read/write scratch register.
- R12: A disabled source never wins and never raises `irq_o`, even while its request line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Hardware interrupt request lines |
| irq_o | output | 1 | Interrupt to the processor |
| addr_i | input | 9 | Byte address |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (used for read-side-effect entry) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |

## Verification
The assertions check four things on every cycle:
- the winner is really pending, and no enabled pending source beats it on level or number;
- an entry sets its level's in-service bit;
- an acknowledge clears the levels it names;
- the held source stays stable between entry and acknowledge, and nesting-off blocks the interrupt.

Only the bench scenarios can show the bus-level effects:
- the register layout;
- which entry mode reacts to which access;
- vector arithmetic against a programmed base;
- preemption order across several nested levels;
- the trigger-clear bit mapping.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int unsigned N_SRC     = 64;
  localparam int unsigned N_LVL     = 4;
  localparam int unsigned SRC_W     = $clog2(N_SRC);
  localparam int unsigned LVL_W     = $clog2(N_LVL);
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 9;
  localparam int unsigned RIDX_W    = ADDR_W - 4;
  localparam int unsigned SLOTS     = 4;
  localparam int unsigned SLOT_W    = DATA_W / SLOTS;
  localparam int unsigned CFG_WORDS = N_SRC / SLOTS;

  localparam logic [RIDX_W-1:0] RI_VEC   = 5'd0;
  localparam logic [RIDX_W-1:0] RI_ACK   = 5'd1;
  localparam logic [RIDX_W-1:0] RI_CTRL  = 5'd2;
  localparam logic [RIDX_W-1:0] RI_STAT  = 5'd3;
  localparam logic [RIDX_W-1:0] RI_RAW0  = 5'd4;
  localparam logic [RIDX_W-1:0] RI_RAW1  = 5'd5;
  localparam logic [RIDX_W-1:0] RI_CFG0  = 5'd6;
  localparam logic [RIDX_W-1:0] RI_VBASE = 5'd22;
  localparam logic [RIDX_W-1:0] RI_CLR0  = 5'd29;
  localparam logic [RIDX_W-1:0] RI_SCR   = 5'd31;

  localparam int unsigned CB_IRQ_EN   = 0;
  localparam int unsigned CB_RD_ENTRY = 1;
  localparam int unsigned CB_NO_NEST  = 2;
  localparam int unsigned CTRL_W      = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic sw;
    logic en;
    lvl_t lvl;
  } src_cfg_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_collector_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  localparam int unsigned IW = $clog2(NS)
) (
  input  logic [NS-1:0]       pend_i,
  input  lvl_t [NS-1:0]       lvl_i,
  output logic                valid_o,
  output logic [IW-1:0]       idx_o,
  output lvl_t                lvl_o
);
  logic [N_LVL-1:0][NS-1:0] lvl_pend;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    for (genvar n = 0; n < NS; n++) begin : g_src
      assign lvl_pend[l][n] = pend_i[n] && (lvl_i[n] == lvl_t'(l));
    end
  end

  // ascending level, descending index: last hit is highest level, lowest index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int l = 0; l < N_LVL; l++) begin
      for (int n = NS - 1; n >= 0; n--) begin
        if (lvl_pend[l][n]) begin
          valid_o = 1'b1;
          idx_o   = IW'(n);
          lvl_o   = lvl_t'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_collector_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic [SRC_W-1:0] win_idx_i,
  input  lvl_t             win_lvl_i,
  input  logic             irq_en_i,
  input  logic             no_nest_i,
  input  logic             enter_req_i,
  input  logic             ack_we_i,
  input  logic [N_LVL-1:0] ack_lvl_i,
  output logic             irq_o,
  output logic [N_LVL-1:0] svc_o,
  output logic             held_o,
  output logic [SRC_W-1:0] held_idx_o
);
  logic [N_LVL-1:0] svc_q, at_or_above, set_mask, clr_mask;
  logic             blocked, enter;
  logic             held_q;
  logic [SRC_W-1:0] held_idx_q;

  for (genvar l = 0; l < N_LVL; l++) begin : g_cmp
    assign at_or_above[l] = (lvl_t'(l) >= win_lvl_i);
  end

  assign blocked  = no_nest_i ? (|svc_q) : (|(svc_q & at_or_above));
  assign irq_o    = irq_en_i && win_valid_i && !blocked;
  assign enter    = enter_req_i && irq_o;
  assign set_mask = enter ? (N_LVL'(1) << win_lvl_i) : '0;
  assign clr_mask = ack_we_i ? ack_lvl_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q      <= '0;
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      svc_q <= (svc_q & ~clr_mask) | set_mask;
      if (enter) begin
        held_q     <= 1'b1;
        held_idx_q <= win_idx_i;
      end else if (ack_we_i) begin
        held_q <= 1'b0;
      end
    end
  end

  assign svc_o      = svc_q;
  assign held_o     = held_q;
  assign held_idx_o = held_idx_q;

  a_r5_enter_sets_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> svc_q[$past(win_lvl_i)]);

  a_r6_ack_clears_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !enter) |=> ((svc_q & $past(ack_lvl_i)) == '0));

  a_r4_held_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !enter && !ack_we_i) |=> (held_q && $stable(held_idx_q)));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  output logic              irq_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [RIDX_W-1:0] widx;
  logic              acc, acc_we, acc_rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-3:0] vbase_q;
  logic [DATA_W-1:0] scr_q;

  src_cfg_t [N_SRC-1:0] cfg_v;
  logic [N_SRC-1:0]     en_v, sw_v, pend;
  lvl_t [N_SRC-1:0]     lvl_v;

  logic             win_valid, held;
  logic [SRC_W-1:0] win_idx, held_idx, cur_src;
  lvl_t             win_lvl;
  logic [N_LVL-1:0] svc;
  logic             enter_req, ack_we;
  logic [DATA_W-1:0] vec_addr;

  assign widx   = addr_i[ADDR_W-1:4];
  assign acc    = (addr_i[3:0] == 4'h0);  // alias offsets not implemented
  assign acc_we = we_i && acc;
  assign acc_rd = rd_i && acc;

  // per-source configuration slots
  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    localparam logic [RIDX_W-1:0] CFG_IDX = RI_CFG0 + RIDX_W'(n / SLOTS);
    localparam logic [RIDX_W-1:0] CLR_IDX = RI_CLR0 + RIDX_W'(n / DATA_W);
    localparam int unsigned       SLOT    = n % SLOTS;
    localparam int unsigned       CBIT    = n % DATA_W;
    src_cfg_t cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (acc_we && widx == CFG_IDX) begin
        cfg_q <= src_cfg_t'(wdata_i[SLOT*SLOT_W +: $bits(src_cfg_t)]);
      end else if (acc_we && widx == CLR_IDX && wdata_i[CBIT]) begin
        cfg_q.sw <= 1'b0;
      end
    end

    assign cfg_v[n] = cfg_q;
    assign en_v[n]  = cfg_q.en;
    assign sw_v[n]  = cfg_q.sw;
    assign lvl_v[n] = cfg_q.lvl;
  end

  assign pend = (req_i | sw_v) & en_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      vbase_q <= '0;
      scr_q   <= '0;
    end else if (acc_we) begin
      case (widx)
        RI_CTRL:  ctrl_q  <= wdata_i[CTRL_W-1:0];
        RI_VBASE: vbase_q <= wdata_i[DATA_W-1:2];
        RI_SCR:   scr_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  irq_pick #(.NS(N_SRC)) u_pick (
    .pend_i  (pend),
    .lvl_i   (lvl_v),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  assign enter_req = ctrl_q[CB_RD_ENTRY] ? (acc_rd && widx == RI_VEC)
                                         : (acc_we && widx == RI_VEC);
  assign ack_we    = acc_we && widx == RI_ACK;

  irq_service u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .win_lvl_i   (win_lvl),
    .irq_en_i    (ctrl_q[CB_IRQ_EN]),
    .no_nest_i   (ctrl_q[CB_NO_NEST]),
    .enter_req_i (enter_req),
    .ack_we_i    (ack_we),
    .ack_lvl_i   (wdata_i[N_LVL-1:0]),
    .irq_o       (irq_o),
    .svc_o       (svc),
    .held_o      (held),
    .held_idx_o  (held_idx)
  );

  assign cur_src  = held ? held_idx : win_idx;
  assign vec_addr = {vbase_q, 2'b00} + {{(DATA_W-SRC_W-2){1'b0}}, cur_src, 2'b00};

  always_comb begin
    rdata_o = '0;
    if (acc) begin
      case (widx)
        RI_VEC:   rdata_o = vec_addr;
        RI_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
        RI_STAT:  rdata_o[SRC_W-1:0] = cur_src;
        RI_RAW0:  rdata_o = req_i[DATA_W-1:0];
        RI_RAW1:  rdata_o = req_i[2*DATA_W-1:DATA_W];
        RI_VBASE: rdata_o = {vbase_q, 2'b00};
        RI_SCR:   rdata_o = scr_q;
        default: begin
          if (widx >= RI_CFG0 && widx < RI_CFG0 + RIDX_W'(CFG_WORDS)) begin
            for (int s = 0; s < SLOTS; s++) begin
              rdata_o[s*SLOT_W +: $bits(src_cfg_t)] =
                cfg_v[SRC_W'((widx - RI_CFG0)) * SRC_W'(SLOTS) + SRC_W'(s)];
            end
          end
        end
      endcase
    end
  end

  // independent check: nobody beats the winner
  logic [N_SRC-1:0] beats;
  for (genvar n = 0; n < N_SRC; n++) begin : g_beat
    assign beats[n] = pend[n] && ((lvl_v[n] > win_lvl) ||
                      (lvl_v[n] == win_lvl && SRC_W'(n) < win_idx));
  end

  a_r2_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (pend[win_idx] && lvl_v[win_idx] == win_lvl));

  a_r2_none_better: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (beats == '0));

  a_r12_idle_no_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (!win_valid && !irq_o));

  a_r7_no_nest_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_NO_NEST] && svc != '0) |-> !irq_o);
endmodule

// File: tb/irq_collector_tb.sv
`timescale 1ns/1ps
module irq_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic        irq;
  logic [8:0]  addr = '0;
  logic        we = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_collector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .irq_o(irq),
    .addr_i(addr), .we_i(we), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic [63:0] req;
    logic        irq;
    logic [5:0]  idx;
  } row_t;

  localparam row_t TBL [8] = '{
    '{64'h0000_0000_0000_0020, 1'b1, 6'd5},
    '{64'h0000_0000_0000_0220, 1'b1, 6'd5},
    '{64'h0000_0000_0000_0200, 1'b1, 6'd9},
    '{64'h8000_0000_0000_0200, 1'b1, 6'd63},
    '{64'h8000_0100_0000_0000, 1'b1, 6'd40},
    '{64'h0000_0000_0010_0000, 1'b0, 6'd0},
    '{64'h0000_0000_0010_0020, 1'b1, 6'd5},
    '{64'h0000_0000_0000_0000, 1'b0, 6'd0}
  };

  localparam logic [31:0] VBASE = 32'h0000_1000;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_strobe(input logic [8:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_req(input logic [63:0] r);
    @(negedge clk);
    req = r;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // R1 reset state
    #1;
    check("R1 irq at reset", irq, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    peek(9'h020, d); check("R1 ctrl reset", d, 0);
    peek(9'h000, d); check("R1 vector reset", d, 0);

    // configuration
    wr(9'h160, VBASE);
    wr(9'h070, 32'h0000_0500);  // src 5: lvl1 en
    wr(9'h080, 32'h0000_0500);  // src 9: lvl1 en
    wr(9'h100, 32'h0000_0007);  // src 40: lvl3 en
    wr(9'h150, 32'h0600_0000);  // src 63: lvl2 en
    wr(9'h0B0, 32'h0000_0003);  // src 20: lvl3 disabled
    peek(9'h150, d); check("R8 cfg readback src63", d, 32'h0600_0000);
    peek(9'h0B0, d); check("R8 cfg readback src20", d, 32'h0000_0003);
    wr(9'h020, 32'h1);

    // R2/R3/R4/R12 arbitration table
    foreach (TBL[i]) begin
      set_req(TBL[i].req);
      check("R3 R12 irq table", irq, TBL[i].irq);
      if (TBL[i].irq) begin
        peek(9'h030, d); check("R2 status table", d, TBL[i].idx);
        peek(9'h000, d); check("R4 vector table", d, VBASE + 4 * TBL[i].idx);
      end
    end

    // R9 raw view, unmasked
    set_req(64'h0000_0002_0000_0004);
    check("R12 disabled lines no irq", irq, 0);
    peek(9'h040, d); check("R9 raw0", d, 32'h4);
    peek(9'h050, d); check("R9 raw1", d, 32'h2);

    // nesting, write entry
    set_req(64'h20);
    wr(9'h000, 0);
    check("R5 write entry blocks same level", irq, 0);
    set_req(64'h8000_0000_0000_0020);
    check("R3 higher level preempts", irq, 1);
    peek(9'h030, d); check("R4 status held after entry", d, 5);
    wr(9'h000, 0);
    check("R5 second entry", irq, 0);
    peek(9'h030, d); check("R4 status held nested", d, 63);
    set_req(64'h8000_0100_0000_0020);
    check("R3 level3 over 1,2", irq, 1);
    wr(9'h010, 32'h4);
    peek(9'h030, d); check("R6 after ack tracks winner", d, 40);
    wr(9'h010, 32'h2);
    set_req(64'h8000_0000_0000_0020);
    wr(9'h000, 0);  // enters 63 (lvl2)
    set_req(64'h20);
    check("R3 lower level blocked", irq, 0);
    wr(9'h010, 32'h4);
    check("R6 ack frees level2", irq, 1);

    // R7 nesting off
    wr(9'h020, 32'h5);
    wr(9'h000, 0);
    set_req(64'h0000_0100_0000_0020);
    check("R7 no nest blocks level3", irq, 0);
    wr(9'h010, 32'h2);
    check("R7 R6 ack releases", irq, 1);

    // R5 read entry mode
    wr(9'h020, 32'h3);
    set_req(64'h20);
    wr(9'h000, 0);
    check("R5 write ignored in read mode", irq, 1);
    rd_strobe(9'h000);
    check("R5 read entry", irq, 0);
    peek(9'h000, d); check("R4 held vector", d, VBASE + 32'h14);
    wr(9'h010, 32'h2);
    wr(9'h020, 32'h1);
    rd_strobe(9'h000);
    check("R5 read ignored in write mode", irq, 1);

    // R3 global enable
    wr(9'h020, 32'h0);
    check("R3 global enable off", irq, 0);
    wr(9'h000, 0);
    wr(9'h020, 32'h1);
    check("R5 no entry while irq low", irq, 1);

    // R8/R10 software trigger
    set_req(64'h0);
    wr(9'h080, 32'h0000_0D00);
    check("R8 software trigger irq", irq, 1);
    peek(9'h030, d); check("R8 software trigger source", d, 9);
    wr(9'h1D0, 32'h0000_0100);
    check("R10 zero bits no effect", irq, 1);
    wr(9'h1D0, 32'h0000_0200);
    check("R10 clear trigger", irq, 0);
    peek(9'h080, d); check("R10 cfg after clear", d, 32'h0000_0500);
    wr(9'h100, 32'h0000_000F);
    check("R8 trigger src40", irq, 1);
    wr(9'h1E0, 32'h0000_0100);
    check("R10 clear word1", irq, 0);

    // R11 scratch
    wr(9'h1F0, 32'hA5A5_1234);
    peek(9'h1F0, d); check("R11 scratch", d, 32'hA5A5_1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule